// File: doc/BRIEF.md
# UART interrupt mask and routing

This block keeps the interrupt state of a UART: a sticky raw status word with one bit per interrupt source, and a mask word that selects which sources may reach the outside. The rest of the UART raises a source by pulsing its bit on `src_set`. A write to the data register address raises the transmit source by itself. Software reads the raw word, the mask and the masked word (raw AND mask) through a small register port. It writes the mask, and it drops raw bits by writing ones to the clear address.

Six level-sensitive lines leave the block. The first is the OR of every masked source. The other five carry the masked receive, transmit, receive-timeout, modem-status and error groups, one group per line. All six lines are registered. They change on the same clock edge as the raw or mask register whose update causes the change.

Source bit layout: bits 0..3 are the modem-status group (ring, clear-to-send, carrier detect, data-set-ready), bit 4 is receive, bit 5 is transmit, bit 6 is receive timeout, and bits 7..10 are the error group (framing, parity, break, overrun). Register addresses on `reg_addr`: 0 data, 1 mask, 2 raw status, 3 masked status, 4 clear.

Top module: `uart_irq_router`

## Requirements
- R1: After reset the mask, the raw status and all six interrupt lines are zero.
- R2: A 1 on bit b of `src_set` sets raw bit b at the next edge. The bit then stays set until it is cleared through the clear address.
- R3: A read of address 3 returns raw AND mask. A read of address 2 returns the raw word.
- R4: A write to address 4 clears every raw bit whose written bit is 1 and leaves the other raw bits unchanged. A read of address 4 returns zero.
- R5: Writes to addresses 2 and 3 change neither the raw word nor the mask.
- R6: `irq_any` is 1 exactly when some bit of raw AND mask is 1.
- R7: `irq_rx` follows masked bit 4, `irq_tx` masked bit 5, `irq_rxto` masked bit 6. `irq_modem` is the OR of masked bits 0..3 and `irq_err` the OR of masked bits 7..10.
- R8: A write to address 0 sets raw bit 5 (transmit).
- R9: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R10: A write to address 1 loads the mask. A read of address 1 returns it. Reads of addresses 0 and 5..7 return zero.
- R11: The six lines show the new raw and mask values right after the edge that loads those registers, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Read data, combinational from `reg_addr` |
| src_set | input | NSRC | Per-source set pulses |
| irq_any | output | 1 | OR of all masked sources |
| irq_rx | output | 1 | Masked receive |
| irq_tx | output | 1 | Masked transmit |
| irq_rxto | output | 1 | Masked receive timeout |
| irq_modem | output | 1 | Masked modem-status group |
| irq_err | output | 1 | Masked error group |

## Verification
Every write and set pulse takes effect at the next rising edge. At that same edge the raw word, the mask and all six lines update, so none of these results has a delay beyond that one edge. Read data is combinational from the address, so a read result is due in the same cycle the address is driven. The bench drives inputs on the falling edge. It compares the lines one time unit after the rising edge. It checks read data while the address is held, before the next rising edge.

// File: rtl/uart_irq_router.sv
module uart_irq_router #(
  parameter int NSRC   = 11,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  input  logic [NSRC-1:0]   src_set,
  output logic              irq_any,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rxto,
  output logic              irq_modem,
  output logic              irq_err
);
  localparam logic [ADDR_W-1:0] A_DATA = 0;
  localparam logic [ADDR_W-1:0] A_MASK = 1;
  localparam logic [ADDR_W-1:0] A_RAW  = 2;
  localparam logic [ADDR_W-1:0] A_MSK  = 3;
  localparam logic [ADDR_W-1:0] A_CLR  = 4;
  localparam int B_RX = 4;
  localparam int B_TX = 5;
  localparam int B_RT = 6;
  localparam int MS_LO = 0, MS_HI = 3;
  localparam int ER_LO = 7, ER_HI = 10;

  logic [NSRC-1:0] raw_q, mask_q, raw_nx, mask_nx, mskd_nx, clr_bits, tx_bit;

  assign clr_bits = (reg_wr && reg_addr == A_CLR) ? reg_wdata : '0;
  assign tx_bit   = (reg_wr && reg_addr == A_DATA) ? NSRC'(1) << B_TX : '0;
  assign raw_nx   = (raw_q & ~clr_bits) | src_set | tx_bit;
  assign mask_nx  = (reg_wr && reg_addr == A_MASK) ? reg_wdata : mask_q;
  assign mskd_nx  = raw_nx & mask_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q     <= '0;
      mask_q    <= '0;
      irq_any   <= 1'b0;
      irq_rx    <= 1'b0;
      irq_tx    <= 1'b0;
      irq_rxto  <= 1'b0;
      irq_modem <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      raw_q     <= raw_nx;
      mask_q    <= mask_nx;
      irq_any   <= |mskd_nx;
      irq_rx    <= mskd_nx[B_RX];
      irq_tx    <= mskd_nx[B_TX];
      irq_rxto  <= mskd_nx[B_RT];
      irq_modem <= |mskd_nx[MS_HI:MS_LO];
      irq_err   <= |mskd_nx[ER_HI:ER_LO];
    end
  end

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = mask_q;
      A_RAW:   reg_rdata = raw_q;
      A_MSK:   reg_rdata = raw_q & mask_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module uart_irq_router_chk #(
  parameter int NSRC   = 11,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NSRC-1:0]   reg_wdata,
  input logic [NSRC-1:0]   reg_rdata,
  input logic [NSRC-1:0]   src_set,
  input logic [NSRC-1:0]   raw_q,
  input logic [NSRC-1:0]   mask_q,
  input logic              irq_any,
  input logic              irq_rx,
  input logic              irq_err
);
  a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd4) |-> (reg_rdata == '0));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 3'd4) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((raw_q & $past(src_set)) == $past(src_set)));

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4) |=> ((raw_q & $past(reg_wdata & ~src_set)) == '0));

  a_r5_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 3'd2 || reg_addr == 3'd3)) |=> $stable(mask_q));

  a_r8_data_sets_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0) |=> raw_q[5]);

  a_r6_any_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == |(raw_q & mask_q));

  a_r7_rx_err_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx == (raw_q[4] & mask_q[4])) && (irq_err == |(raw_q[10:7] & mask_q[10:7])));
endmodule

bind uart_irq_router uart_irq_router_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_set(src_set),
  .raw_q(raw_q), .mask_q(mask_q), .irq_any(irq_any), .irq_rx(irq_rx),
  .irq_err(irq_err)
);

// File: tb/uart_irq_router_tb.sv
`timescale 1ns/1ps
module uart_irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [10:0] reg_wdata = '0;
  logic [10:0] reg_rdata;
  logic [10:0] src_set = '0;
  logic irq_any, irq_rx, irq_tx, irq_rxto, irq_modem, irq_err;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [10:0] m_raw = '0, m_mask = '0;

  always #4 clk = ~clk;

  uart_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_set(src_set),
    .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rxto(irq_rxto),
    .irq_modem(irq_modem), .irq_err(irq_err)
  );

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_lines(input logic [10:0] r, input logic [10:0] m);
    logic [10:0] x = r & m;
    return {|x, x[4], x[5], x[6], |x[3:0], |x[10:7]};
  endfunction

  task automatic check_lines(input string tag);
    check(tag, {5'd0, irq_any, irq_rx, irq_tx, irq_rxto, irq_modem, irq_err},
          {5'd0, exp_lines(m_raw, m_mask)});
  endtask

  // one cycle: drive at falling edge, model the edge, check after it
  task automatic step(input logic wr, input logic [2:0] a, input logic [10:0] d,
                      input logic [10:0] s, input string tag);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; src_set = s;
    @(posedge clk); #1;
    if (wr && a == 3'd1) m_mask = d;
    if (wr && a == 3'd4) m_raw = m_raw & ~d;
    if (wr && a == 3'd0) m_raw[5] = 1'b1;
    m_raw = m_raw | s;
    check_lines(tag);
    reg_wr = 1'b0; src_set = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [10:0] exp, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a; src_set = '0;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic rd_all;
    rd(3'd1, m_mask, "R10 mask read");
    rd(3'd2, m_raw, "R3 raw read");
    rd(3'd3, m_raw & m_mask, "R3 masked read");
    rd(3'd4, 11'd0, "R4 clear reads zero");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 lines after reset", {5'd0, irq_any, irq_rx, irq_tx, irq_rxto, irq_modem, irq_err}, 11'd0);
    rd(3'd1, 11'd0, "R1 mask reset");
    rd(3'd2, 11'd0, "R1 raw reset");

    // R2 / R11: set with mask zero -> lines stay low, bit sticks
    step(0, 3'd0, 0, 11'h010, "R2 set rx unmasked");
    step(0, 3'd0, 0, 11'h000, "R2 sticky");
    rd(3'd2, 11'h010, "R2 raw holds rx");
    // R11 mask write makes line rise at the same edge
    step(1, 3'd1, 11'h010, 0, "R11 mask enables rx line");
    check("R7 irq_rx high", {10'd0, irq_rx}, 11'd1);
    // R8 data write
    step(1, 3'd0, 11'h0AA, 0, "R8 data write sets tx");
    rd(3'd2, 11'h030, "R8 raw has tx bit 5");
    // R5 writes to raw/masked ignored
    step(1, 3'd2, 11'h7FF, 0, "R5 raw write ignored");
    step(1, 3'd3, 11'h000, 0, "R5 masked write ignored");
    rd_all;
    // R7 groups
    step(1, 3'd1, 11'h7FF, 0, "R10 mask all");
    step(0, 3'd0, 0, 11'h400, "R7 overrun -> err");
    check("R7 irq_err high", {10'd0, irq_err}, 11'd1);
    step(0, 3'd0, 0, 11'h004, "R7 dcd -> modem");
    check("R7 irq_modem high", {10'd0, irq_modem}, 11'd1);
    // R4 partial clear
    step(1, 3'd4, 11'h404, 0, "R4 clear err and modem");
    rd(3'd2, 11'h030, "R4 other bits kept");
    // R9 set beats clear
    step(1, 3'd4, 11'h040, 11'h040, "R9 set wins over clear");
    rd(3'd2, 11'h070, "R9 rt bit set");
    check("R7 irq_rxto high", {10'd0, irq_rxto}, 11'd1);
    step(1, 3'd4, 11'h7FF, 0, "R4 clear all");
    check("R6 irq_any low after clear", {10'd0, irq_any}, 11'd0);
    rd(3'd0, 11'd0, "R10 data address reads zero");
    rd(3'd6, 11'd0, "R10 unmapped reads zero");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      logic [10:0] s;
      a = 3'($urandom_range(0, 6));
      s = ($urandom_range(0, 3) == 0) ? 11'($urandom) & 11'($urandom) : 11'd0;
      step($urandom_range(0, 1) == 1, a, 11'($urandom), s, "R6 R7 R9 random step");
      if (i % 7 == 0) rd_all;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule